// File: doc/BRIEF.md
# Register Window Occupancy Tracker

This block keeps the bookkeeping for a ring of register windows in a 64-bit processor core. It holds four occupancy counters, a current-window pointer and a 6-bit trap-vector selector. The counters are: windows free to save into, windows that can be restored, windows owned by another context, and windows known to be clean. Five command strobes arrive from the pipeline: save, restore, flush-all-windows, saved and restored. On each command the block either moves the pointer and counters, or it reports a spill, fill or clean-window trap with a 9-bit trap type. No state changes on a trapping command.

The spill and fill trap types depend on the selector register. When other-context windows are still pending, the upper selector field is used together with an "other" flag. Otherwise the lower selector field is used. The saved and restored commands, which the trap handlers issue, consume other-context windows first. A load port writes the whole state in one cycle. This port is how privileged writes and the bench reach arbitrary occupancy states.

Top module: `win_occ_unit`

## Requirements
- R1: After reset: free = NWIN-2, restorable = 0, other = 0, clean = NWIN-1, pointer = 0, selector = 0, no trap.
- R2: Save with free = 0 raises a spill trap, type 0x080 OR the selector value of R6, and leaves all state unchanged.
- R3: Save with free ≠ 0 and clean = restorable raises trap type 0x024 and leaves all state unchanged.
- R4: Any other save decrements free, increments restorable, and moves the pointer down by one, from 0 wrapping to NWIN-1.
- R5: Restore with restorable = 0 raises a fill trap, type 0x0C0 OR the selector value of R6, with no state change. Any other restore increments free, decrements restorable, and moves the pointer up by one, from NWIN-1 wrapping to 0.
- R6: Selector value: when other ≠ 0 it is 0x020 OR (selector bits 5:3 placed at bits 4:2). When other = 0 it is selector bits 2:0 placed at bits 4:2.
- R7: Flush raises a spill trap (type as in R2) unless free = NWIN-2. It never changes state.
- R8: Saved increments free. It then decrements other if other ≠ 0, and decrements restorable otherwise.
- R9: Restored increments restorable, and increments clean only while clean < NWIN-1. It then decrements other if other ≠ 0, and decrements free otherwise.
- R10: The load strobe writes all six state values and overrides any command strobe in the same cycle. When several command strobes are high together, only one acts: save first, then restore, flush, saved, restored.
- R11: The trap outputs are registered and due in the cycle after the command. Trap-valid is a one-cycle pulse, and the trap type reads 0 whenever trap-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_i | input | 1 | Save command strobe |
| restore_i | input | 1 | Restore command strobe |
| flushw_i | input | 1 | Flush-all-windows command strobe |
| saved_i | input | 1 | Saved command (spill handler finished) |
| restored_i | input | 1 | Restored command (fill handler finished) |
| ld_i | input | 1 | Load all state from the ld_* inputs |
| ld_cansave_i | input | CW | Free-window count to load |
| ld_canrestore_i | input | CW | Restorable count to load |
| ld_otherwin_i | input | CW | Other-context count to load |
| ld_cleanwin_i | input | CW | Clean count to load |
| ld_cwp_i | input | CW | Window pointer to load |
| ld_wstate_i | input | 6 | Trap-vector selector to load |
| cansave_o | output | CW | Free-window count |
| canrestore_o | output | CW | Restorable count |
| otherwin_o | output | CW | Other-context count |
| cleanwin_o | output | CW | Clean count |
| cwp_o | output | CW | Current window pointer |
| wstate_o | output | 6 | Trap-vector selector |
| trap_valid_o | output | 1 | Trap raised by the previous command |
| trap_type_o | output | 9 | Trap type, 0 when no trap |

## Verification
Every result of this block is due exactly one clock edge after its strobe. Counter and pointer updates, the trap-valid pulse and the trap type all come out of registers written on that edge. A load also takes effect one edge after ld_i is sampled. The bench drives all strobes on the falling edge and samples on the next falling edge, halfway between the edge that produced the result and the edge that would overwrite it. Each operation in the sweep is a load, then a check of the loaded state, then one command, then a comparison of all outputs against an arithmetic model.

// File: rtl/woc_pkg.sv
package woc_pkg;
   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_SAVE,
      CMD_RESTORE,
      CMD_FLUSH,
      CMD_SAVED,
      CMD_RESTORED
   } woc_cmd_e;

   localparam int TT_W  = 9;
   localparam int WS_W  = 6;
   localparam logic [TT_W-1:0] TT_SPILL_BASE = 9'h080;
   localparam logic [TT_W-1:0] TT_FILL_BASE  = 9'h0C0;
   localparam logic [TT_W-1:0] TT_OTHER_FLAG = 9'h020;
   localparam logic [TT_W-1:0] TT_CLEAN      = 9'h024;
endpackage

// File: rtl/woc_cmd_sel.sv
module woc_cmd_sel
   import woc_pkg::*;
(
   input  logic     save_i,
   input  logic     restore_i,
   input  logic     flushw_i,
   input  logic     saved_i,
   input  logic     restored_i,
   output woc_cmd_e cmd_o
);
   always_comb begin
      if (save_i)          cmd_o = CMD_SAVE;
      else if (restore_i)  cmd_o = CMD_RESTORE;
      else if (flushw_i)   cmd_o = CMD_FLUSH;
      else if (saved_i)    cmd_o = CMD_SAVED;
      else if (restored_i) cmd_o = CMD_RESTORED;
      else                 cmd_o = CMD_NONE;
   end
endmodule

// File: rtl/woc_trap_code.sv
module woc_trap_code
   import woc_pkg::*;
(
   input  logic            is_fill_i,
   input  logic            other_pend_i,
   input  logic [WS_W-1:0] wstate_i,
   output logic [TT_W-1:0] tt_o
);
   logic [TT_W-1:0] base;
   logic [TT_W-1:0] sel;

   always_comb begin
      base = is_fill_i ? TT_FILL_BASE : TT_SPILL_BASE;
      if (other_pend_i)
         sel = TT_OTHER_FLAG | {4'b0000, wstate_i[5:3], 2'b00};
      else
         sel = {4'b0000, wstate_i[2:0], 2'b00};
      tt_o = base | sel;
   end
endmodule

// File: rtl/woc_wrap_step.sv
module woc_wrap_step #(
   parameter int NWIN = 8,
   parameter int CW   = $clog2(NWIN)
) (
   input  logic [CW-1:0] val_i,
   input  logic          up_i,
   output logic [CW-1:0] val_o
);
   localparam logic [CW-1:0] ONE  = CW'(1);
   localparam logic [CW-1:0] MAXV = CW'(NWIN - 1);
   localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

   generate
      if (POW2) begin : g_pow2
         always_comb val_o = up_i ? val_i + ONE : val_i - ONE;
      end else begin : g_cmp
         always_comb begin
            if (up_i) val_o = (val_i == MAXV) ? '0 : val_i + ONE;
            else      val_o = (val_i == '0) ? MAXV : val_i - ONE;
         end
      end
   endgenerate
endmodule

// File: rtl/win_occ_unit.sv
module win_occ_unit
   import woc_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int CW   = $clog2(NWIN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            save_i,
   input  logic            restore_i,
   input  logic            flushw_i,
   input  logic            saved_i,
   input  logic            restored_i,
   input  logic            ld_i,
   input  logic [CW-1:0]   ld_cansave_i,
   input  logic [CW-1:0]   ld_canrestore_i,
   input  logic [CW-1:0]   ld_otherwin_i,
   input  logic [CW-1:0]   ld_cleanwin_i,
   input  logic [CW-1:0]   ld_cwp_i,
   input  logic [WS_W-1:0] ld_wstate_i,
   output logic [CW-1:0]   cansave_o,
   output logic [CW-1:0]   canrestore_o,
   output logic [CW-1:0]   otherwin_o,
   output logic [CW-1:0]   cleanwin_o,
   output logic [CW-1:0]   cwp_o,
   output logic [WS_W-1:0] wstate_o,
   output logic            trap_valid_o,
   output logic [TT_W-1:0] trap_type_o
);
   localparam logic [CW-1:0] ONE     = CW'(1);
   localparam logic [CW-1:0] CS_RST  = CW'(NWIN - 2);
   localparam logic [CW-1:0] CLN_MAX = CW'(NWIN - 1);

   generate
      if (NWIN < 3 || NWIN > 32) begin : g_bad_nwin
         $error("win_occ_unit: NWIN must be in 3..32");
      end
      if (CW != $clog2(NWIN)) begin : g_bad_cw
         $error("win_occ_unit: CW must equal clog2(NWIN)");
      end
   endgenerate

   logic [CW-1:0]   cs_q, cr_q, ow_q, cl_q, cwp_q;
   logic [CW-1:0]   cs_n, cr_n, ow_n, cl_n, cwp_n;
   logic [WS_W-1:0] ws_q, ws_n;
   logic            tv_q, tv_n;
   logic [TT_W-1:0] tt_q, tt_n;
   logic [CW-1:0]   cwp_step;
   logic [TT_W-1:0] sf_code;
   woc_cmd_e        cmd;

   woc_cmd_sel u_sel (
      .save_i     (save_i),
      .restore_i  (restore_i),
      .flushw_i   (flushw_i),
      .saved_i    (saved_i),
      .restored_i (restored_i),
      .cmd_o      (cmd)
   );

   woc_wrap_step #(.NWIN(NWIN), .CW(CW)) u_step (
      .val_i (cwp_q),
      .up_i  (cmd == CMD_RESTORE),
      .val_o (cwp_step)
   );

   woc_trap_code u_code (
      .is_fill_i    (cmd == CMD_RESTORE),
      .other_pend_i (ow_q != '0),
      .wstate_i     (ws_q),
      .tt_o         (sf_code)
   );

   always_comb begin
      cs_n  = cs_q;
      cr_n  = cr_q;
      ow_n  = ow_q;
      cl_n  = cl_q;
      cwp_n = cwp_q;
      ws_n  = ws_q;
      tv_n  = 1'b0;
      tt_n  = '0;
      if (ld_i) begin
         cs_n  = ld_cansave_i;
         cr_n  = ld_canrestore_i;
         ow_n  = ld_otherwin_i;
         cl_n  = ld_cleanwin_i;
         cwp_n = ld_cwp_i;
         ws_n  = ld_wstate_i;
      end else begin
         unique case (cmd)
            CMD_SAVE: begin
               if (cs_q == '0) begin
                  tv_n = 1'b1;
                  tt_n = sf_code;
               end else if (cl_q == cr_q) begin
                  tv_n = 1'b1;
                  tt_n = TT_CLEAN;
               end else begin
                  cs_n  = cs_q - ONE;
                  cr_n  = cr_q + ONE;
                  cwp_n = cwp_step;
               end
            end
            CMD_RESTORE: begin
               if (cr_q == '0) begin
                  tv_n = 1'b1;
                  tt_n = sf_code;
               end else begin
                  cs_n  = cs_q + ONE;
                  cr_n  = cr_q - ONE;
                  cwp_n = cwp_step;
               end
            end
            CMD_FLUSH: begin
               if (cs_q != CS_RST) begin
                  tv_n = 1'b1;
                  tt_n = sf_code;
               end
            end
            CMD_SAVED: begin
               cs_n = cs_q + ONE;
               if (ow_q != '0) ow_n = ow_q - ONE;
               else            cr_n = cr_q - ONE;
            end
            CMD_RESTORED: begin
               cr_n = cr_q + ONE;
               if (cl_q < CLN_MAX) cl_n = cl_q + ONE;
               if (ow_q != '0) ow_n = ow_q - ONE;
               else            cs_n = cs_q - ONE;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= CS_RST;
         cr_q  <= '0;
         ow_q  <= '0;
         cl_q  <= CLN_MAX;
         cwp_q <= '0;
         ws_q  <= '0;
         tv_q  <= 1'b0;
         tt_q  <= '0;
      end else begin
         cs_q  <= cs_n;
         cr_q  <= cr_n;
         ow_q  <= ow_n;
         cl_q  <= cl_n;
         cwp_q <= cwp_n;
         ws_q  <= ws_n;
         tv_q  <= tv_n;
         tt_q  <= tt_n;
      end
   end

   assign cansave_o    = cs_q;
   assign canrestore_o = cr_q;
   assign otherwin_o   = ow_q;
   assign cleanwin_o   = cl_q;
   assign cwp_o        = cwp_q;
   assign wstate_o     = ws_q;
   assign trap_valid_o = tv_q;
   assign trap_type_o  = tt_q;
endmodule

// File: rtl/woc_chk.sv
module woc_chk #(
   parameter int NWIN = 8,
   parameter int CW   = $clog2(NWIN)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          save_i,
   input logic          restore_i,
   input logic          flushw_i,
   input logic          saved_i,
   input logic          restored_i,
   input logic          ld_i,
   input logic [CW-1:0] cansave_o,
   input logic [CW-1:0] canrestore_o,
   input logic [CW-1:0] otherwin_o,
   input logic [CW-1:0] cleanwin_o,
   input logic [CW-1:0] cwp_o,
   input logic          trap_valid_o,
   input logic [8:0]    trap_type_o
);
   assert_spill_on_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && !ld_i && cansave_o == '0)
      |=> (trap_valid_o && trap_type_o[8:6] == 3'b010 && $stable(cansave_o) && $stable(cwp_o)));

   assert_clean_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && !ld_i && cansave_o != '0 && cleanwin_o == canrestore_o)
      |=> (trap_valid_o && trap_type_o == 9'h024));

   assert_save_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && !ld_i && cansave_o != '0 && cleanwin_o != canrestore_o)
      |=> (!trap_valid_o
           && cansave_o == CW'($past(cansave_o) - 1'b1)
           && canrestore_o == CW'($past(canrestore_o) + 1'b1)));

   assert_fill_on_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_i && !save_i && !ld_i && canrestore_o == '0)
      |=> (trap_valid_o && trap_type_o[8:6] == 3'b011));

   assert_flush_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flushw_i && !save_i && !restore_i && !ld_i)
      |=> ($stable(cansave_o) && $stable(canrestore_o) && $stable(otherwin_o)
           && $stable(cwp_o)));

   assert_saved_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (saved_i && !save_i && !restore_i && !flushw_i && !ld_i)
      |=> (cansave_o == CW'($past(cansave_o) + 1'b1) && !trap_valid_o));

   assert_clean_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (restored_i && !save_i && !restore_i && !flushw_i && !saved_i && !ld_i
       && cleanwin_o == CW'(NWIN - 1))
      |=> $stable(cleanwin_o));

   assert_trap_freezes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_o |-> ($past(!ld_i) && cansave_o == $past(cansave_o)
                        && canrestore_o == $past(canrestore_o) && cwp_o == $past(cwp_o)));
endmodule

bind win_occ_unit woc_chk #(.NWIN(NWIN), .CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .save_i       (save_i),
   .restore_i    (restore_i),
   .flushw_i     (flushw_i),
   .saved_i      (saved_i),
   .restored_i   (restored_i),
   .ld_i         (ld_i),
   .cansave_o    (cansave_o),
   .canrestore_o (canrestore_o),
   .otherwin_o   (otherwin_o),
   .cleanwin_o   (cleanwin_o),
   .cwp_o        (cwp_o),
   .trap_valid_o (trap_valid_o),
   .trap_type_o  (trap_type_o)
);

// File: tb/win_occ_unit_tb.sv
module win_occ_unit_tb;
   localparam int NWIN = 8;
   localparam int CW   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic save_i = 0, restore_i = 0, flushw_i = 0, saved_i = 0, restored_i = 0, ld_i = 0;
   logic [CW-1:0] ld_cs = 0, ld_cr = 0, ld_ow = 0, ld_cl = 0, ld_cwp = 0;
   logic [5:0]    ld_ws = 0;
   logic [CW-1:0] cs, cr, ow, cl, cwp;
   logic [5:0]    ws;
   logic          tv;
   logic [8:0]    tt;

   int errs = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   win_occ_unit #(.NWIN(NWIN)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .save_i(save_i), .restore_i(restore_i), .flushw_i(flushw_i),
      .saved_i(saved_i), .restored_i(restored_i), .ld_i(ld_i),
      .ld_cansave_i(ld_cs), .ld_canrestore_i(ld_cr), .ld_otherwin_i(ld_ow),
      .ld_cleanwin_i(ld_cl), .ld_cwp_i(ld_cwp), .ld_wstate_i(ld_ws),
      .cansave_o(cs), .canrestore_o(cr), .otherwin_o(ow), .cleanwin_o(cl),
      .cwp_o(cwp), .wstate_o(ws), .trap_valid_o(tv), .trap_type_o(tt)
   );

   function automatic logic [30:0] pack(int a, int b, int c, int d, int e, int w, int v, int t);
      return {3'(a), 3'(b), 3'(c), 3'(d), 3'(e), 6'(w), 1'(v), 9'(t)};
   endfunction

   function automatic logic [30:0] observed();
      return {cs, cr, ow, cl, cwp, ws, tv, tt};
   endfunction

   task automatic check(string req, logic [30:0] act, logic [30:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   // selector value per R6
   function automatic int sel_of(int o, int w);
      if (o != 0) return 32 | (((w >> 3) & 7) << 2);
      return (w & 7) << 2;
   endfunction

   task automatic load(int a, int b, int c, int d, int e, int w);
      ld_cs = 3'(a); ld_cr = 3'(b); ld_ow = 3'(c); ld_cl = 3'(d); ld_cwp = 3'(e); ld_ws = 6'(w);
      ld_i = 1;
      @(negedge clk);
      ld_i = 0;
      check("R10 load", observed(), pack(a, b, c, d, e, w, 0, 0));
   endtask

   task automatic strobe(int k);
      save_i = (k == 0); restore_i = (k == 1); flushw_i = (k == 2);
      saved_i = (k == 3); restored_i = (k == 4);
      @(negedge clk);
      save_i = 0; restore_i = 0; flushw_i = 0; saved_i = 0; restored_i = 0;
   endtask

   initial begin
      #(4 * 150000);
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 reset", observed(), pack(NWIN - 2, 0, 0, NWIN - 1, 0, 0, 0, 0));

      for (int a = 0; a < 8; a++)
         for (int om = 0; om < 2; om++)
            for (int v = 0; v < 8; v++)
               for (int k = 0; k < 5; k++) begin
                  int b, c, d, w, na, nb, nc, nd, ne, etv, ett;
                  string req;
                  b = (a + v) % 8;
                  c = om ? (v % 3) + 1 : 0;
                  d = (v % 3 == 0) ? b : (b + v) % 8;
                  w = (a * 9 + v * 5) % 64;
                  na = a; nb = b; nc = c; nd = d; ne = v; etv = 0; ett = 0;
                  case (k)
                     0: if (a == 0) begin
                           etv = 1; ett = 'h080 | sel_of(c, w); req = "R2 save spill, R6";
                        end else if (d == b) begin
                           etv = 1; ett = 'h024; req = "R3 clean trap";
                        end else begin
                           na = (a + 7) % 8; nb = (b + 1) % 8; ne = (v + 7) % 8; req = "R4 save";
                        end
                     1: if (b == 0) begin
                           etv = 1; ett = 'h0C0 | sel_of(c, w); req = "R5 fill, R6";
                        end else begin
                           na = (a + 1) % 8; nb = (b + 7) % 8; ne = (v + 1) % 8; req = "R5 restore";
                        end
                     2: begin
                           req = "R7 flush";
                           if (a != NWIN - 2) begin etv = 1; ett = 'h080 | sel_of(c, w); end
                        end
                     3: begin
                           req = "R8 saved";
                           na = (a + 1) % 8;
                           if (c != 0) nc = c - 1; else nb = (b + 7) % 8;
                        end
                     default: begin
                           req = "R9 restored";
                           nb = (b + 1) % 8;
                           if (d < NWIN - 1) nd = d + 1;
                           if (c != 0) nc = c - 1; else na = (a + 7) % 8;
                        end
                  endcase
                  load(a, b, c, d, v, w);
                  strobe(k);
                  check(req, observed(), pack(na, nb, nc, nd, ne, w, etv, ett));
               end

      // R10: several strobes at once, save wins; R11: pulse lasts one cycle
      load(0, 3, 0, 5, 2, 6'h2A);
      save_i = 1; restore_i = 1; saved_i = 1;
      @(negedge clk);
      save_i = 0; restore_i = 0; saved_i = 0;
      check("R10 priority", observed(), pack(0, 3, 0, 5, 2, 6'h2A, 1, 'h080 | 8));
      @(negedge clk);
      check("R11 pulse ends", observed(), pack(0, 3, 0, 5, 2, 6'h2A, 0, 0));

      // R10: load overrides a command strobe
      ld_cs = 3; ld_cr = 1; ld_ow = 0; ld_cl = 4; ld_cwp = 0; ld_ws = 0;
      ld_i = 1; save_i = 1;
      @(negedge clk);
      ld_i = 0; save_i = 0;
      check("R10 load over save", observed(), pack(3, 1, 0, 4, 0, 0, 0, 0));

      // R4: pointer wraps 0 -> 7 on save
      strobe(0);
      check("R4 wrap down", observed(), pack(2, 2, 0, 4, 7, 0, 0, 0));
      // R5: pointer wraps 7 -> 0 on restore
      strobe(1);
      check("R5 wrap up", observed(), pack(3, 1, 0, 4, 0, 0, 0, 0));

      finish_run();
   end
endmodule